// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block accepts the three-wire programming stream of a frequency synthesizer: a serial clock, a serial data line and a load strobe. All three are asynchronous to the system clock. They are synchronized and oversampled in the system clock domain. Each rising edge of the serial clock shifts one data bit into a frame register. A frame is 20 bits long: an 18-bit payload, sent most significant bit first, followed by a 2-bit destination code.

A rising edge on the load strobe commits the frame to one of two holding registers. The destination code decides which one. The reference register keeps the 17 low payload bits as the reference divide ratio. The divider register keeps all 18 payload bits, split into a 14-bit main count (upper bits) and a 4-bit swallow count (lower bits). The divider counters read these registers directly. Each register has a one-cycle update strobe and a sticky valid flag.

The stream carries no data flow that can stall, so the block has no valid/ready handshake. All pins are plain control and status signals, and nothing can push back on the serial source.

Top module: `synth_serial_prog`

## Requirements
- R1: After reset, both registers read zero, both valid flags are low and both update strobes are low.
- R2: Data is captured on rising edges of the serial clock, most significant payload bit first. The last two bits captured form the destination code: the earlier one is code bit 1 and the final one is code bit 0.
- R3: Destination code 11 loads payload bits 16..0 into the reference register and pulses the reference strobe. The divider register does not change.
- R4: Destination code 01 loads payload bits 17..4 into the main count and bits 3..0 into the swallow count, and pulses the divider strobe. The reference register does not change.
- R5: Destination codes 00 and 10 are ignored. Neither register changes and no strobe pulses.
- R6: Each rising edge of the load strobe gives at most one update strobe lasting exactly one cycle, however long the load strobe stays high.
- R7: Each valid flag stays low until the first write of its register, then stays high until reset.
- R8: The two update strobes are never high in the same cycle. A register changes only in the cycle its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_load | input | 1 | Load strobe, commit on rising edge (asynchronous) |
| ref_word | output | 17 | Reference divide ratio |
| ref_upd | output | 1 | One-cycle pulse when the reference register is written |
| ref_valid | output | 1 | Reference register has been written since reset |
| div_main | output | 14 | Main counter value of the divider word |
| div_swal | output | 4 | Swallow counter value of the divider word |
| div_upd | output | 1 | One-cycle pulse when the divider register is written |
| div_valid | output | 1 | Divider register has been written since reset |

## Verification
Frames are sent with alternating, walking and all-ones payloads, so that a bit-order or field-split error shows up as a wrong value rather than a coincidence. The same payload is sent to both destinations to show that the code, and not the data, picks the register. Codes 00 and 10 are sent before and after valid writes to tell "ignored" apart from "written with equal data". A load strobe held high for many cycles separates edge-triggered commit from level-triggered repeats.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    DEST_NONE_A = 2'b00,
    DEST_DIV    = 2'b01,
    DEST_NONE_B = 2'b10,
    DEST_REF    = 2'b11
  } dest_e;

  localparam int unsigned DEST_W = 2;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[i]};
    end
    assign sync_out[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ssp_frame.sv
module ssp_frame #(
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               load_s,
  output logic [FRAME_W-1:0] frame,
  output logic               commit
);
  logic sclk_q;
  logic load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      load_q <= 1'b0;
      frame  <= '0;
    end else begin
      sclk_q <= sclk_s;
      load_q <= load_s;
      if (sclk_s && !sclk_q) frame <= {frame[FRAME_W-2:0], sdat_s};
    end
  end

  assign commit = load_s && !load_q;
endmodule

// File: rtl/ssp_latches.sv
module ssp_latches
  import ssp_pkg::*;
#(
  parameter int unsigned REF_W  = 17,
  parameter int unsigned MAIN_W = 14,
  parameter int unsigned SWAL_W = 4,
  parameter int unsigned PAY_W  = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [PAY_W+DEST_W-1:0] frame,
  output logic [REF_W-1:0]        ref_word,
  output logic                    ref_upd,
  output logic                    ref_valid,
  output logic [MAIN_W-1:0]       div_main,
  output logic [SWAL_W-1:0]       div_swal,
  output logic                    div_upd,
  output logic                    div_valid
);
  localparam int unsigned DIV_W = MAIN_W + SWAL_W;

  dest_e            dest;
  logic [PAY_W-1:0] payload;
  logic             hit_ref;
  logic             hit_div;

  assign dest    = dest_e'(frame[DEST_W-1:0]);
  assign payload = frame[PAY_W+DEST_W-1:DEST_W];
  assign hit_ref = commit && (dest == DEST_REF);
  assign hit_div = commit && (dest == DEST_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_word  <= '0;
      ref_upd   <= 1'b0;
      ref_valid <= 1'b0;
      div_main  <= '0;
      div_swal  <= '0;
      div_upd   <= 1'b0;
      div_valid <= 1'b0;
    end else begin
      ref_upd <= hit_ref;
      div_upd <= hit_div;
      if (hit_ref) begin
        ref_word  <= payload[REF_W-1:0];
        ref_valid <= 1'b1;
      end
      if (hit_div) begin
        div_main  <= payload[DIV_W-1:SWAL_W];
        div_swal  <= payload[SWAL_W-1:0];
        div_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_serial_prog.sv
module synth_serial_prog
  import ssp_pkg::*;
#(
  parameter int unsigned REF_W       = 17,
  parameter int unsigned MAIN_W      = 14,
  parameter int unsigned SWAL_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_word,
  output logic              ref_upd,
  output logic              ref_valid,
  output logic [MAIN_W-1:0] div_main,
  output logic [SWAL_W-1:0] div_swal,
  output logic              div_upd,
  output logic              div_valid
);
  localparam int unsigned PAY_W   = max_u(REF_W, MAIN_W + SWAL_W);
  localparam int unsigned FRAME_W = PAY_W + DEST_W;

  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] frame;
  logic               commit;

  ssp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_load, ser_dat, ser_clk}),
    .sync_out (pins_s)
  );

  ssp_frame #(.FRAME_W(FRAME_W)) i_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (pins_s[0]),
    .sdat_s (pins_s[1]),
    .load_s (pins_s[2]),
    .frame  (frame),
    .commit (commit)
  );

  ssp_latches #(
    .REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .PAY_W(PAY_W)
  ) i_latches (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .frame     (frame),
    .ref_word  (ref_word),
    .ref_upd   (ref_upd),
    .ref_valid (ref_valid),
    .div_main  (div_main),
    .div_swal  (div_swal),
    .div_upd   (div_upd),
    .div_valid (div_valid)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int unsigned REF_W  = 17,
  parameter int unsigned MAIN_W = 14,
  parameter int unsigned SWAL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REF_W-1:0]  ref_word,
  input logic              ref_upd,
  input logic              ref_valid,
  input logic [MAIN_W-1:0] div_main,
  input logic [SWAL_W-1:0] div_swal,
  input logic              div_upd,
  input logic              div_valid
);
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_upd && div_upd)); // R8
  AST_REF_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd); // R6
  AST_DIV_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    div_upd |=> !div_upd); // R6
  AST_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> $stable(ref_word)); // R8
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_upd |-> ($stable(div_main) && $stable(div_swal))); // R8
  AST_REF_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |-> ref_valid); // R7
  AST_DIV_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    div_upd |-> div_valid); // R7
  AST_REF_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ref_valid) |-> ref_valid); // R7
  AST_DIV_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_valid) |-> div_valid); // R7
endmodule

bind synth_serial_prog ssp_checker #(
  .REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W)
) i_ssp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_word  (ref_word),
  .ref_upd   (ref_upd),
  .ref_valid (ref_valid),
  .div_main  (div_main),
  .div_swal  (div_swal),
  .div_upd   (div_upd),
  .div_valid (div_valid)
);

// File: tb/test_synth_serial_prog.sv
module test_synth_serial_prog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_load = 1'b0;
  logic [16:0] ref_word;
  logic        ref_upd;
  logic        ref_valid;
  logic [13:0] div_main;
  logic [3:0]  div_swal;
  logic        div_upd;
  logic        div_valid;

  typedef struct {
    bit          is_ref;
    logic [17:0] val;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          n_pushed = 0;
  int          n_strobes = 0;
  bit          finished = 0;
  logic [16:0] last_ref = '0;
  logic [17:0] last_div = '0;

  always #2 clk = ~clk;

  synth_serial_prog i_synth_serial_prog (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .ref_word(ref_word), .ref_upd(ref_upd),
    .ref_valid(ref_valid), .div_main(div_main), .div_swal(div_swal),
    .div_upd(div_upd), .div_valid(div_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [17:0] pay, input logic [1:0] dest,
                            input int hold);
    logic [19:0] f;
    f = {pay, dest};
    for (int i = 19; i >= 0; i--) begin
      ser_dat = f[i];
      repeat (4) @(posedge clk);
      ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
    end
    repeat (2) @(posedge clk);
    if (dest == 2'b11) begin
      exp_q.push_back('{1'b1, pay}); n_pushed++; last_ref = pay[16:0];
    end else if (dest == 2'b01) begin
      exp_q.push_back('{1'b0, pay}); n_pushed++; last_div = pay;
    end
    ser_load = 1'b1;
    repeat (hold) @(posedge clk);
    ser_load = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  // monitor: pops expected items as strobes appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ref_upd && div_upd) check(1'b0, "R8 both strobes", 2, 1);
      if (ref_upd || div_upd) begin
        exp_t e;
        n_strobes++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R6 unexpected strobe", {30'd0, ref_upd, div_upd}, 0);
        end else begin
          e = exp_q.pop_front();
          if (e.is_ref) begin
            check(ref_upd, "R3 reference strobe", ref_upd, 1);
            check(ref_word == e.val[16:0], "R3 reference value", ref_word, e.val[16:0]);
          end else begin
            check(div_upd, "R4 divider strobe", div_upd, 1);
            check(div_main == e.val[17:4], "R4 main count", div_main, e.val[17:4]);
            check(div_swal == e.val[3:0], "R4 swallow count", div_swal, e.val[3:0]);
          end
        end
      end
    end
  end

  task automatic check_hold(input string req);
    @(negedge clk);
    check(ref_word == last_ref, req, ref_word, last_ref);
    check({div_main, div_swal} == last_div, req, {div_main, div_swal}, last_div);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ref_word == 0 && div_main == 0 && div_swal == 0, "R1 registers zero",
          {div_main, div_swal} | ref_word, 0);
    check(!ref_valid && !div_valid, "R1 valid low", {ref_valid, div_valid}, 0);
    check(!ref_upd && !div_upd, "R1 strobes low", {ref_upd, div_upd}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    send_frame(18'h2AAAA, 2'b00, 4);              // R5 ignored before any write
    check_hold("R5 code 00 ignored");
    @(negedge clk);
    check(!ref_valid && !div_valid, "R7 valid still low", {ref_valid, div_valid}, 0);

    send_frame(18'h1ABCD, 2'b11, 4);              // R2 R3
    @(negedge clk);
    check(ref_valid && !div_valid, "R7 only reference valid", {ref_valid, div_valid}, 2'b10);
    check_hold("R3 divider untouched");

    send_frame(18'h2D3C5, 2'b01, 4);              // R2 R4
    check_hold("R4 reference untouched");
    @(negedge clk);
    check(div_valid && ref_valid, "R7 both valid", {ref_valid, div_valid}, 2'b11);

    send_frame(18'h15555, 2'b10, 4);              // R5
    check_hold("R5 code 10 ignored");
    send_frame(18'h3FFFF, 2'b00, 4);
    check_hold("R5 code 00 ignored after writes");

    send_frame(18'h00001, 2'b11, 4);              // walking one, R2
    send_frame(18'h20000, 2'b01, 4);
    send_frame(18'h3FFFF, 2'b11, 60);             // R6 long load
    send_frame(18'h3FFFF, 2'b01, 60);
    check_hold("R6 long load result");

    repeat (20) @(posedge clk);
    check(exp_q.size() == 0, "R3/R4 all writes seen", exp_q.size(), 0);
    check(n_strobes == n_pushed, "R6 one strobe per load", n_strobes, n_pushed);
    @(negedge clk);
    check(ref_valid && div_valid, "R7 valid sticky", {ref_valid, div_valid}, 2'b11);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule